// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block sequences a processor-side local bus one clock at a time. A requester presents an address and a cycle type together with a valid level. The sequencer takes that request when it launches the cycle and drives the address with a one-clock strobe. It then waits in data clocks until the external ready input closes the cycle.

If the system raises next-address during a data clock, the sequencer may put the following address on the bus before the current cycle ends. Back-to-back pipelined cycles can then take just two clocks each. It distinguishes a data clock where pipelining was granted but nothing is waiting from one where the next address has already gone out. A single external master may take the bus with a hold request. The sequencer grants it only once the cycle in flight has ended, and releases its own address drivers for as long as the grant lasts.

Top module: `bus_pipe_seq`

## Requirements
- R1: Reset puts the sequencer in idle. `bus_phase` encodes the state as idle=0, address=1, data=2, pipelined-wait=3, pipelined-address=4, pipelined-first=5, hold=6. After reset the strobe and `hold_ack` are low and `bus_oe` is high.
- R2: In idle or at the end of a cycle, a valid request with hold low is taken (`req_take` high in that clock). The next clock is the address state, with the strobe high for that one clock and the request's address and type on the bus.
- R3: The address state is always followed by the data state. Ready is ignored in the address and pipelined-first states.
- R4: When next-address is high in a data or pipelined-first clock and no request can be launched, the next state is pipelined-wait. The strobe stays low and the bus address is unchanged.
- R5: When next-address is high in a data or pipelined-first clock, or the state is pipelined-wait, a valid request with hold low is taken. The next state is pipelined-address, with the strobe high for its first clock only and the new address driven.
- R6: Ready in the pipelined-address state ends the current cycle, and the next state is pipelined-first with no strobe. The pipelined-first, pipelined-address pair can repeat with each cycle lasting two clocks.
- R7: `cyc_done` is high exactly in the clocks where ready is high in the data, pipelined-wait or pipelined-address state.
- R8: While hold is high, no new cycle is launched, and the cycle in flight still runs to ready. The clock after that ready the state is hold, with `hold_ack` high and both `bus_oe` and the strobe low.
- R9: The sequencer stays in hold while hold is high. The clock after hold falls it enters the address state if a request is valid, otherwise idle.
- R10: In idle, a hold request takes priority over a valid request.
- R11: The bus address and type change only on the clock edge that follows `req_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request pending |
| req_addr | input | AW | Address of the pending request |
| req_kind | input | TW | Cycle type of the pending request |
| bus_ready | input | 1 | External ready, ends the cycle in a data state |
| next_addr | input | 1 | Permission to issue the next address early |
| hold_req | input | 1 | External master asks for the bus |
| addr_strobe | output | 1 | Address strobe, one clock per launched cycle |
| bus_addr | output | AW | Driven address |
| bus_kind | output | TW | Driven cycle type |
| bus_oe | output | 1 | Address and strobe drivers enabled |
| hold_ack | output | 1 | Bus granted to the external master |
| req_take | output | 1 | Request accepted in this clock |
| cyc_done | output | 1 | Current cycle finishes in this clock |
| bus_phase | output | 3 | Current state code |

## Verification
The bench builds the sequencer with AW=16 and TW=2. These widths are narrow enough for readable addresses, yet still let every launched cycle carry a distinct address and type. A wrong latch edge in R11 therefore shows up as a wrong value. The fixed parameters do not limit state coverage, since all seven states and every transition between them are reachable from the ports. A long random run with a biased next-address input drives the pipelined states repeatedly and mixes in hold at every possible state.

// File: rtl/bus_pipe_seq.sv
module bus_pipe_seq #(
  parameter int AW = 32,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] req_kind,
  input  logic          bus_ready,
  input  logic          next_addr,
  input  logic          hold_req,
  output logic          addr_strobe,
  output logic [AW-1:0] bus_addr,
  output logic [TW-1:0] bus_kind,
  output logic          bus_oe,
  output logic          hold_ack,
  output logic          req_take,
  output logic          cyc_done,
  output logic [2:0]    bus_phase
);

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_ADDR       = 3'd1,
    PH_DATA       = 3'd2,
    PH_PIPE_WAIT  = 3'd3,
    PH_PIPE_ADDR  = 3'd4,
    PH_PIPE_FIRST = 3'd5,
    PH_HOLD       = 3'd6
  } phase_t;

  phase_t        ph, ph_nx;
  logic          strobe_q;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] kind_q;

  logic in_data, can_pipe, bnd_take;
  phase_t bnd_next, pipe_next;

  assign in_data   = (ph == PH_DATA) || (ph == PH_PIPE_WAIT) || (ph == PH_PIPE_ADDR);
  assign cyc_done  = bus_ready & in_data;
  assign can_pipe  = req_valid & ~hold_req;
  assign bnd_take  = req_valid & ~hold_req;
  assign bnd_next  = hold_req ? PH_HOLD : (req_valid ? PH_ADDR : PH_IDLE);
  assign pipe_next = can_pipe ? PH_PIPE_ADDR : PH_PIPE_WAIT;

  always_comb begin
    ph_nx    = ph;
    req_take = 1'b0;
    case (ph)
      PH_IDLE, PH_HOLD: begin
        ph_nx    = bnd_next;
        req_take = bnd_take;
      end
      PH_ADDR: ph_nx = PH_DATA;
      PH_PIPE_FIRST: begin
        if (next_addr) begin
          ph_nx    = pipe_next;
          req_take = can_pipe;
        end else begin
          ph_nx = PH_DATA;
        end
      end
      PH_DATA: begin
        if (bus_ready) begin
          ph_nx    = bnd_next;
          req_take = bnd_take;
        end else if (next_addr) begin
          ph_nx    = pipe_next;
          req_take = can_pipe;
        end
      end
      PH_PIPE_WAIT: begin
        if (bus_ready) begin
          ph_nx    = bnd_next;
          req_take = bnd_take;
        end else if (can_pipe) begin
          ph_nx    = PH_PIPE_ADDR;
          req_take = 1'b1;
        end
      end
      PH_PIPE_ADDR: if (bus_ready) ph_nx = PH_PIPE_FIRST;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      strobe_q <= 1'b0;
      addr_q   <= '0;
      kind_q   <= '0;
    end else begin
      ph       <= ph_nx;
      strobe_q <= req_take;
      if (req_take) begin
        addr_q <= req_addr;
        kind_q <= req_kind;
      end
    end
  end

  assign addr_strobe = strobe_q;
  assign bus_addr    = addr_q;
  assign bus_kind    = kind_q;
  assign hold_ack    = (ph == PH_HOLD);
  assign bus_oe      = (ph != PH_HOLD);
  assign bus_phase   = ph;

endmodule

// File: rtl/bus_pipe_seq_chk.sv
module bus_pipe_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          addr_strobe,
  input logic          hold_ack,
  input logic          bus_oe,
  input logic          req_take,
  input logic          cyc_done,
  input logic [2:0]    bus_phase,
  input logic [AW-1:0] bus_addr
);

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe);

  assert_take_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> addr_strobe);

  assert_addr_to_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase == 3'd1) |=> (bus_phase == 3'd2));

  assert_pipe_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && bus_phase == 3'd4) |=> (bus_phase == 3'd5 && !addr_strobe));

  assert_done_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (bus_phase == 3'd2 || bus_phase == 3'd3 || bus_phase == 3'd4));

  assert_no_launch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |-> !req_take);

  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_oe && !addr_strobe));

  assert_ack_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req));

  assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_take |=> $stable(bus_addr));

endmodule

bind bus_pipe_seq bus_pipe_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .addr_strobe(addr_strobe),
  .hold_ack(hold_ack), .bus_oe(bus_oe), .req_take(req_take),
  .cyc_done(cyc_done), .bus_phase(bus_phase), .bus_addr(bus_addr)
);

// File: tb/bus_pipe_seq_bench.sv
module bus_pipe_seq_bench;
  localparam int AW = 16;
  localparam int TW = 2;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_kind = '0;
  logic          bus_ready = 1'b0, next_addr = 1'b0, hold_req = 1'b0;
  logic          addr_strobe, bus_oe, hold_ack, req_take, cyc_done;
  logic [AW-1:0] bus_addr;
  logic [TW-1:0] bus_kind;
  logic [2:0]    bus_phase;

  always #(PERIOD/2) clk = ~clk;

  bus_pipe_seq #(.AW(AW), .TW(TW)) u_bus_pipe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .bus_ready(bus_ready), .next_addr(next_addr),
    .hold_req(hold_req), .addr_strobe(addr_strobe), .bus_addr(bus_addr),
    .bus_kind(bus_kind), .bus_oe(bus_oe), .hold_ack(hold_ack),
    .req_take(req_take), .cyc_done(cyc_done), .bus_phase(bus_phase)
  );

  int n_cmp = 0, n_bad = 0;
  int aq[$];
  int kq[$];
  int m_ph = 0, m_stb = 0, m_addr = 0, m_kind = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(int a, int k);
    aq.push_back(a);
    kq.push_back(k);
  endtask

  task automatic step(string tag, bit h, bit n, bit r);
    int e_take, e_done, e_next, rv;
    bit data_st;
    @(negedge clk);
    hold_req  = h;
    next_addr = n;
    bus_ready = r;
    rv = (aq.size() > 0) ? 1 : 0;
    req_valid = rv[0];
    req_addr  = rv != 0 ? AW'(aq[0]) : '0;
    req_kind  = rv != 0 ? TW'(kq[0]) : '0;
    #1;
    data_st = (m_ph == 2 || m_ph == 3 || m_ph == 4);
    e_done  = (r && data_st) ? 1 : 0;
    e_take  = 0;
    e_next  = m_ph;
    if (m_ph == 0 || m_ph == 6 || ((m_ph == 2 || m_ph == 3) && r)) begin
      e_next = h ? 6 : (rv != 0 ? 1 : 0);
      e_take = (!h && rv != 0) ? 1 : 0;
    end else if (m_ph == 1) begin
      e_next = 2;
    end else if (m_ph == 4) begin
      e_next = r ? 5 : 4;
    end else if (m_ph == 3) begin
      if (!h && rv != 0) begin e_next = 4; e_take = 1; end
    end else if (m_ph == 2 || m_ph == 5) begin
      if (n) begin
        e_take = (!h && rv != 0) ? 1 : 0;
        e_next = e_take != 0 ? 4 : 3;
      end else begin
        e_next = 2;
      end
    end
    chk(tag, "phase", int'(bus_phase), m_ph);
    chk(tag, "strobe", int'(addr_strobe), m_stb);
    chk(tag, "addr", int'(bus_addr), m_addr);
    chk(tag, "kind", int'(bus_kind), m_kind);
    chk(tag, "hold_ack", int'(hold_ack), m_ph == 6 ? 1 : 0);
    chk(tag, "oe", int'(bus_oe), m_ph == 6 ? 0 : 1);
    chk(tag, "take", int'(req_take), e_take);
    chk(tag, "done", int'(cyc_done), e_done);
    if (e_take != 0) begin
      m_addr = aq.pop_front();
      m_kind = kq.pop_front();
    end
    m_stb = e_take;
    m_ph  = e_next;
  endtask

  initial begin
    #(PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "phase", int'(bus_phase), 0);
    chk("R1", "strobe", int'(addr_strobe), 0);
    chk("R1", "hold_ack", int'(hold_ack), 0);
    chk("R1", "oe", int'(bus_oe), 1);
    rst_n = 1'b1;
    step("R1", 0, 0, 0);

    // plain cycle, ready ignored in address state
    push(16'h1234, 1);
    step("R2", 0, 0, 0);
    step("R3", 0, 0, 1);
    step("R7", 0, 0, 0);
    step("R7", 0, 0, 1);
    step("R1", 0, 0, 0);

    // pipelining: wait, then address, then back-to-back pairs
    push(16'h2000, 2);
    step("R2", 0, 0, 0);
    step("R3", 0, 0, 0);
    step("R4", 0, 1, 0);
    step("R4", 0, 0, 0);
    push(16'h2004, 3);
    step("R5", 0, 0, 0);
    step("R5", 0, 0, 0);
    step("R6", 0, 0, 1);
    push(16'h2008, 0);
    step("R6", 0, 1, 0);
    step("R6", 0, 0, 1);
    step("R3", 0, 0, 1);
    step("R7", 0, 0, 1);
    step("R11", 0, 0, 0);

    // hold during a cycle blocks pipelining, grant at the boundary
    push(16'h3000, 1);
    step("R2", 0, 0, 0);
    step("R8", 1, 0, 0);
    push(16'h3333, 2);
    step("R8", 1, 1, 0);
    step("R8", 1, 0, 0);
    step("R8", 1, 0, 1);
    step("R9", 1, 0, 0);
    step("R9", 1, 0, 1);
    step("R9", 0, 0, 0);
    step("R9", 0, 0, 0);
    step("R7", 0, 0, 1);
    step("R11", 0, 0, 0);

    // hold wins over a request at idle; release with and without requests
    push(16'h4444, 3);
    step("R10", 1, 0, 0);
    step("R10", 1, 0, 0);
    step("R9", 0, 0, 0);
    step("R9", 0, 0, 0);
    step("R7", 1, 0, 1);
    step("R9", 0, 0, 0);
    step("R9", 0, 0, 0);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 4) == 0 && aq.size() < 4) push(int'($urandom % 65536), int'($urandom % 4));
      step("R11", ($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule